// File: doc/BRIEF.md
# Serial Bit-Rate Clock Generator

This block produces the bit-rate timing for a synchronous serial port. It takes a stream of source pulses and returns a one-cycle bit tick plus a serial clock with an exact 50% duty cycle. Every signal runs in one system clock domain. The source pulses come from one of two places, chosen by a select bit:

- a reference clock enable, `ref_tick`, which is one system cycle wide per reference period;
- the rising edges of an asynchronous external clock, `ext_clk`, after synchronization.

Counted pulses first pass through a fixed halving stage. A programmable divider then divides by the 8-bit `divisor` value plus one. One bit period therefore spans 2*(N+1) source pulses. With the standard 3.6864 MHz reference, divisor values 0 to 255 give bit rates from 1.8432 Mbps down to 7.2 kbps. The external clock goes through the same halving stage.

The serial clock is high for the first half of each bit period and low for the second half. The bit tick marks the start of each new period. The block restarts cleanly when its configuration changes, and it is held quiet while disabled.

Top module: `bitrate_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released with `en` low, `bit_tick` and `sclk` are both 0.
- R2: With `src_ext` = 0, every cycle in which `ref_tick` is 1 counts one source pulse, at the next clock edge. Activity on `ext_clk` has no effect on the outputs.
- R3: With `src_ext` = 1, every rising edge of `ext_clk` counts one source pulse. If `ext_clk` first reads 1 in cycle c, the pulse is counted at the edge that ends cycle c+2, and the outputs show it in cycle c+3. `ref_tick` has no effect in this mode.
- R4: Let N be the divisor. The count of pulses modulo 2*(N+1) is the position in the bit period. `bit_tick` is 1 for exactly one cycle, in the cycle after the edge that counts pulse number 2*(N+1) of a period. It is never 1 in two cycles in a row.
- R5: `sclk` is 1 while the position is 0..N and 0 while the position is N+1..2N+1. So it is 1 in any cycle where `bit_tick` is 1.
- R6: N = 0 gives a bit period of 2 source pulses. N = 255 gives a bit period of 512 source pulses.
- R7: A change of `divisor` or `src_ext` while `en` is 1 returns the position to 0 at the next edge. Any pulse at that edge is dropped and `bit_tick` stays 0. In the following cycle `sclk` is 1, and the new divisor applies from then on.
- R8: When `en` is 0, `sclk` is 0 in that same cycle. At the next edge the position is cleared and source pulses are ignored. After `en` returns to 1, a full fresh period follows, starting with `sclk` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Runs the generator; when 0, counters held at zero |
| src_ext | input | 1 | 0: count `ref_tick`; 1: count rising edges of `ext_clk` |
| divisor | input | 8 | Divider setting N; divides the halved rate by N+1 |
| ref_tick | input | 1 | One-cycle enable per reference clock period |
| ext_clk | input | 1 | Asynchronous external clock |
| bit_tick | output | 1 | One-cycle pulse at the start of each bit period |
| sclk | output | 1 | Serial clock, 50% duty, one period per bit |

## Verification
The two sources have different latencies:

- A `ref_tick` driven in cycle c is counted at the next edge, so any change it causes shows in cycle c+1.
- An external rising edge first seen in cycle c passes two synchronizer flops and an edge flop, so it shows in cycle c+3.
- A configuration change made in cycle c takes effect in cycle c+1.
- Dropping `en` pulls `sclk` low in cycle c itself.

The driver computes the cycle in which each stimulus becomes visible from these latencies and queues the expected tick and clock level under that cycle number. The monitor samples on the falling edge and compares every cycle. A cycle with no queued item must show no tick and an unchanged clock level.

// File: rtl/br_pkg.sv
package br_pkg;

  // Serial clock level for a position inside the bit period.
  function automatic logic br_sclk_high(input int unsigned pos, input int unsigned limit);
    return pos <= limit;
  endfunction

  // True when the divider count has reached its terminal value.
  function automatic logic br_at_limit(input int unsigned cnt, input int unsigned limit);
    return cnt == limit;
  endfunction

  // Bit period length measured in counted source pulses.
  function automatic int unsigned br_period(input int unsigned limit);
    return 2 * (limit + 1);
  endfunction

endpackage

// File: rtl/br_ext_sync.sv
module br_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], ext_in};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_in;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/br_prescale.sv
module br_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic phase,
  output logic half_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase <= 1'b0;
    else if (clear) phase <= 1'b0;
    else if (step)  phase <= ~phase;
  end

  // Every second accepted step passes on to the divider.
  assign half_pulse = step & phase & ~clear;
endmodule

// File: rtl/br_divider.sv
module br_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [DIV_W-1:0] limit,
  output logic [DIV_W-1:0] count,
  output logic             wrap
);
  logic at_end;

  assign at_end = br_pkg::br_at_limit(32'(count), 32'(limit));
  assign wrap   = step & at_end & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= at_end ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             src_ext,
  input  logic [DIV_W-1:0] divisor,
  input  logic             ref_tick,
  input  logic             ext_clk,
  output logic             bit_tick,
  output logic             sclk
);
  localparam int CFG_W = DIV_W + 1;
  localparam int POS_W = DIV_W + 1;

  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic [DIV_W-1:0] divisor_q;
  logic             restart, clear;
  logic             ext_rise, src_pulse;
  logic             phase, half_pulse;
  logic [DIV_W-1:0] dcnt;
  logic             wrap;
  logic             bit_tick_q;
  logic [POS_W-1:0] pos;

  // Configuration snapshot; any difference while running forces a restart.
  assign cfg_now = {src_ext, divisor};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_now;
  end

  assign divisor_q = cfg_q[DIV_W-1:0];
  assign restart   = en & (cfg_now != cfg_q);
  assign clear     = ~en | restart;

  br_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_in (ext_clk),
    .rise   (ext_rise)
  );

  assign src_pulse = en & (src_ext ? ext_rise : ref_tick);

  br_prescale u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .step       (src_pulse),
    .phase      (phase),
    .half_pulse (half_pulse)
  );

  br_divider #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .step  (half_pulse),
    .limit (divisor_q),
    .count (dcnt),
    .wrap  (wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_tick_q <= 1'b0;
    else        bit_tick_q <= wrap;
  end

  // Position inside the bit period, counted in source pulses.
  assign pos      = {dcnt, phase};
  assign bit_tick = bit_tick_q;
  assign sclk     = en & br_pkg::br_sclk_high(32'(pos), 32'(divisor_q));
endmodule

// File: rtl/br_checker.sv
module br_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             bit_tick,
  input logic             sclk,
  input logic             src_pulse,
  input logic             half_pulse,
  input logic             ext_rise,
  input logic             restart,
  input logic             phase,
  input logic [DIV_W-1:0] dcnt,
  input logic [DIV_W-1:0] divisor_q
);
  assert_idle_sclk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !sclk);

  assert_idle_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> !bit_tick);

  assert_tick_sclk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sclk);

  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  assert_half_from_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    half_pulse |-> src_pulse);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (dcnt <= divisor_q));

  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (dcnt == '0 && !phase && !bit_tick));

  assert_hold_no_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && !src_pulse) |=> ($stable(phase) && $stable(dcnt)));

  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
endmodule

bind bitrate_gen br_checker #(.DIV_W(DIV_W)) u_br_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .bit_tick   (bit_tick),
  .sclk       (sclk),
  .src_pulse  (src_pulse),
  .half_pulse (half_pulse),
  .ext_rise   (ext_rise),
  .restart    (restart),
  .phase      (phase),
  .dcnt       (dcnt),
  .divisor_q  (divisor_q)
);

// File: tb/bitrate_gen_tb_top.sv
module bitrate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       src_ext = 1'b0;
  logic [7:0] divisor = 8'd0;
  logic       ref_tick = 1'b0;
  logic       ext_clk = 1'b0;
  logic       bit_tick;
  logic       sclk;

  always #10 clk = ~clk;

  bitrate_gen dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .src_ext  (src_ext),
    .divisor  (divisor),
    .ref_tick (ref_tick),
    .ext_clk  (ext_clk),
    .bit_tick (bit_tick),
    .sclk     (sclk)
  );

  typedef struct packed {
    logic [31:0] cyc;
    logic        tick;
    logic        lvl;
  } exp_item_t;

  exp_item_t   sb_q[$];
  int unsigned cyc = 0;
  int          checks = 0;
  int          failures = 0;
  string       cur_req = "R1";
  bit          mon_on = 1'b0;
  logic        exp_sclk = 1'b0;
  int          pos_m = 0;
  int          n_m = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  // Bench model of one counted source pulse; pushes what the outputs show then.
  task automatic count_pulse(input int unsigned at_cyc);
    exp_item_t it;
    pos_m++;
    it.tick = 1'b0;
    if (pos_m == 2 * (n_m + 1)) begin
      pos_m   = 0;
      it.tick = 1'b1;
    end
    it.cyc = at_cyc;
    it.lvl = (pos_m <= n_m);
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse_ref(input int n, input int gap, input bit wiggle_ext);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      ref_tick = 1'b1;
      if (wiggle_ext) ext_clk = ~ext_clk;
      if (en && !src_ext) count_pulse(cyc + 1);
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1;
        ref_tick = 1'b0;
      end
    end
    @(posedge clk); #1;
    ref_tick = 1'b0;
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      ext_clk = 1'b1;
      count_pulse(cyc + 3);
      @(posedge clk); #1;
      @(posedge clk); #1;
      ext_clk = 1'b0;
      @(posedge clk); #1;
    end
  endtask

  task automatic set_en(input bit v);
    exp_item_t it;
    @(posedge clk); #1;
    en     = v;
    pos_m  = 0;
    it.cyc = cyc;
    it.tick = 1'b0;
    it.lvl = v;
    sb_q.push_back(it);
  endtask

  // Live reconfiguration: position cleared one edge later, clock level high.
  task automatic set_cfg_live(input int n, input bit src);
    exp_item_t it;
    @(posedge clk); #1;
    divisor = n[7:0];
    src_ext = src;
    n_m     = n;
    pos_m   = 0;
    it.cyc  = cyc + 1;
    it.tick = 1'b0;
    it.lvl  = 1'b1;
    sb_q.push_back(it);
    @(posedge clk);
  endtask

  // Monitor: pops items due this cycle and compares outputs every cycle.
  always @(negedge clk) begin
    if (mon_on) begin
      logic exp_tick;
      exp_tick = 1'b0;
      while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
        exp_item_t it;
        it = sb_q.pop_front();
        if (it.cyc < cyc) check(1'b0, cur_req, "stale expected item", it.cyc, cyc);
        exp_tick = exp_tick | it.tick;
        exp_sclk = it.lvl;
      end
      check(bit_tick === exp_tick, cur_req, "bit_tick", bit_tick, exp_tick);
      check(sclk === exp_sclk, "R5", "sclk", sclk, exp_sclk);
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    // R1: reset state
    idle(3);
    @(negedge clk);
    check(bit_tick === 1'b0, "R1", "bit_tick in reset", bit_tick, 0);
    check(sclk === 1'b0, "R1", "sclk in reset", sclk, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(bit_tick === 1'b0 && sclk === 1'b0, "R1", "outputs after reset", {bit_tick, sclk}, 0);
    mon_on = 1'b1;

    // R8: pulses while disabled do nothing
    cur_req = "R8";
    @(posedge clk); #1;
    divisor = 8'd3;
    n_m = 3;
    idle(3);
    pulse_ref(6, 0, 1);
    idle(2);

    // R2: reference source, back-to-back pulses, external clock wiggling
    cur_req = "R2";
    set_en(1'b1);
    pulse_ref(40, 0, 1);

    // R4: spaced pulses
    cur_req = "R4";
    pulse_ref(20, 2, 0);

    // R7 then R6: fastest setting
    cur_req = "R7";
    set_cfg_live(0, 1'b0);
    cur_req = "R6";
    pulse_ref(12, 0, 0);

    // R7 then R6: slowest setting
    cur_req = "R7";
    set_cfg_live(255, 1'b0);
    cur_req = "R6";
    pulse_ref(1100, 0, 0);
    idle(2);

    // R8: disable mid-period, pulses ignored
    cur_req = "R8";
    set_en(1'b0);
    pulse_ref(6, 1, 1);
    idle(2);

    // R3: external source with reference held active
    @(posedge clk); #1;
    divisor  = 8'd2;
    src_ext  = 1'b1;
    ext_clk  = 1'b0;
    ref_tick = 1'b1;
    n_m = 2;
    idle(4);
    cur_req = "R3";
    set_en(1'b1);
    pulse_ext(20);
    @(posedge clk); #1;
    ref_tick = 1'b0;
    idle(4);

    // R7: switch source back to reference while running
    cur_req = "R7";
    set_cfg_live(1, 1'b0);
    cur_req = "R2";
    pulse_ref(9, 1, 0);
    idle(4);

    @(negedge clk);
    check(sb_q.size() == 0, "R4", "unconsumed expected items", sb_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule